// File: doc/BRIEF.md
# Zero-Page Bit-Test Branch Sequencer

This block carries out the two conditional bit-test branches of an 8-bit processor in zero-page bit-relative addressing. A start pulse brings in the address of the instruction. The sequencer then reads three instruction bytes through a byte-wide synchronous read port: the opcode, a zero-page address and a signed displacement. Next it reads the addressed byte from page zero and tests one bit of it. When it finishes, it reports the address of the next instruction, whether the branch was taken, and a one-cycle completion strobe.

The opcode has two fields. The upper three bits select which bit is tested. The lower five bits select the instruction: one pattern branches when the bit is clear, another branches when it is set. Any other pattern ends the instruction early and raises an illegal-opcode flag.

Top module: `zp_bitbr_seq`

## Requirements
- R1: After reset, done, taken and illegal are 0, busy is 0, mem_rd is 0 and next_pc is 0000h.
- R2: For a legal opcode at address A, the block reads in consecutive cycles from A, A+1, A+2 and then {00h, first operand byte}, with four reads in total. Each read's data is taken from mem_rdata in the cycle after its address is presented.
- R3: The tested bit index is opcode[7:5]. For example, opcode B7h tests bit 5.
- R4: When opcode[4:0] is 10111b (17h), the branch is taken exactly when the tested bit is 0.
- R5: When opcode[4:0] is 00111b (07h), the branch is taken exactly when the tested bit is 1.
- R6: A taken branch gives next_pc = A + 3 + sign-extended displacement, modulo 2^16. For example, displacement F1h gives A − 12.
- R7: A branch that is not taken gives next_pc = A + 3, modulo 2^16.
- R8: For any other value of opcode[4:0], done pulses with illegal = 1, taken = 0 and next_pc = A. Only the opcode read is made.
- R9: done is high for exactly one cycle. next_pc, taken and illegal keep their values after done until the next instruction completes.
- R10: A start pulse while busy is 1 is ignored, and the running instruction completes with its own address.
- R11: For a legal opcode, done rises on the fifth rising edge after the edge that samples start. For an illegal opcode, it rises on the second such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction at start_pc |
| start_pc | input | 16 | Address of the instruction's opcode byte |
| mem_addr | output | 16 | Read address |
| mem_rd | output | 1 | Read request, valid with mem_addr |
| mem_rdata | input | 8 | Read data, one cycle after the request |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion strobe |
| taken | output | 1 | The branch was taken |
| illegal | output | 1 | The opcode was not recognised |
| next_pc | output | 16 | Address of the next instruction |

## Verification
The hardest case to reach from the ports is a branch that wraps the 16-bit address space while its instruction bytes also wrap from FFFFh into page zero. The bench places an instruction near the top of memory with a positive displacement. It then checks both the wrapped result and the wrapped fetch addresses. It also sends a second start pulse partway through an instruction, to show that the request is dropped and not queued. The bench sweeps all eight bit positions with bytes that have only the selected bit set, so a wrong bit index cannot go unnoticed.

// File: rtl/zp_bitbr_seq.sv
module zp_bitbr_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] start_pc,
  output logic [15:0] mem_addr,
  output logic        mem_rd,
  input  logic [7:0]  mem_rdata,
  output logic        busy,
  output logic        done,
  output logic        taken,
  output logic        illegal,
  output logic [15:0] next_pc
);

  typedef enum logic [2:0] {IDLE, FETCH_OP, FETCH_ZP, FETCH_DISP, READ_ZP, RESOLVE} st_t;
  st_t st;

  logic [15:0] pc_q;
  logic [7:0]  op_q, zp_q, disp_q;

  wire op_legal  = (mem_rdata[4:0] == 5'h17) || (mem_rdata[4:0] == 5'h07);
  wire sel_bit   = mem_rdata[op_q[7:5]];
  wire go        = op_q[4] ? ~sel_bit : sel_bit;
  wire [15:0] seq_pc = pc_q + 16'd3;
  wire [15:0] br_pc  = seq_pc + {{8{disp_q[7]}}, disp_q};

  assign busy   = (st != IDLE);
  assign mem_rd = (st == FETCH_OP) || (st == FETCH_DISP) || (st == READ_ZP) ||
                  ((st == FETCH_ZP) && op_legal);

  always_comb begin
    case (st)
      FETCH_ZP:   mem_addr = pc_q + 16'd1;
      FETCH_DISP: mem_addr = pc_q + 16'd2;
      READ_ZP:    mem_addr = {8'h00, zp_q};
      default:    mem_addr = pc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= IDLE;
      pc_q    <= '0;
      op_q    <= '0;
      zp_q    <= '0;
      disp_q  <= '0;
      done    <= 1'b0;
      taken   <= 1'b0;
      illegal <= 1'b0;
      next_pc <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          pc_q <= start_pc;
          st   <= FETCH_OP;
        end
        FETCH_OP: st <= FETCH_ZP;
        FETCH_ZP: begin
          op_q <= mem_rdata;
          if (op_legal) st <= FETCH_DISP;
          else begin
            st      <= IDLE;
            done    <= 1'b1;
            illegal <= 1'b1;
            taken   <= 1'b0;
            next_pc <= pc_q;
          end
        end
        FETCH_DISP: begin
          zp_q <= mem_rdata;
          st   <= READ_ZP;
        end
        READ_ZP: begin
          disp_q <= mem_rdata;
          st     <= RESOLVE;
        end
        RESOLVE: begin
          st      <= IDLE;
          done    <= 1'b1;
          illegal <= 1'b0;
          taken   <= go;
          next_pc <= go ? br_pc : seq_pc;
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R8
  illegal_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && illegal) |-> (!taken && next_pc == pc_q));

  // R7
  fallthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal && !taken) |-> (next_pc == pc_q + 16'd3));

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(pc_q));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(done)) |-> ($stable(next_pc) && $stable(taken)));

  // R2
  read_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_rd |-> busy);

endmodule

// File: tb/sim_zp_bitbr_seq.sv
module sim_zp_bitbr_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] start_pc = '0;
  logic [15:0] mem_addr;
  logic mem_rd;
  logic [7:0] mem_rdata = '0;
  logic busy, done, taken, illegal;
  logic [15:0] next_pc;

  int checks = 0;
  int fails = 0;
  logic [7:0]  mem [256];
  logic [15:0] rlog [8];
  int rcnt = 0;

  always #2.5 clk = ~clk;

  zp_bitbr_seq u0 (.clk(clk), .rst_n(rst_n), .start(start), .start_pc(start_pc),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata), .busy(busy),
    .done(done), .taken(taken), .illegal(illegal), .next_pc(next_pc));

  always @(posedge clk) if (mem_rd) begin
    mem_rdata <= mem[mem_addr[7:0]];
    if (rcnt < 8) rlog[rcnt] = mem_addr;
    rcnt = rcnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [15:0] a, input logic [7:0] op, input logic [7:0] zp,
                      input logic [7:0] disp, input logic [7:0] val);
    mem[a[7:0]] = op;
    mem[8'(a[7:0] + 8'd1)] = zp;
    mem[8'(a[7:0] + 8'd2)] = disp;
    mem[zp] = val;
  endtask

  task automatic run(input logic [15:0] a, input logic [7:0] op, input logic [7:0] zp,
                     input logic [7:0] disp, input logic [7:0] val, input bit busy_poke);
    int k;
    bit exp_leg, exp_tk;
    logic [15:0] exp_pc;
    load(a, op, zp, disp, val);
    exp_leg = (op[4:0] == 5'h17) || (op[4:0] == 5'h07);
    exp_tk  = exp_leg && ((op[4:0] == 5'h17) ? !val[op[7:5]] : val[op[7:5]]);
    exp_pc  = !exp_leg ? a : exp_tk ? a + 16'd3 + {{8{disp[7]}}, disp} : a + 16'd3;
    @(negedge clk);
    rcnt = 0;
    start = 1'b1; start_pc = a;
    @(negedge clk);
    start = 1'b0;
    k = 1;
    while (!done && k < 20) begin
      @(negedge clk);
      k++;
      if (busy_poke && k == 2) begin start = 1'b1; start_pc = 16'h5555; end
      else start = 1'b0;
    end
    start = 1'b0;
    chk(k == (exp_leg ? 6 : 3), "R11 latency", k, exp_leg ? 6 : 3);
    chk(illegal == !exp_leg, "R8 illegal flag", illegal, !exp_leg);
    chk(taken == exp_tk, exp_leg ? (op[4] ? "R4 clear-test taken" : "R5 set-test taken") : "R8 taken",
        taken, exp_tk);
    chk(next_pc == exp_pc, exp_tk ? "R6 branch target" : (exp_leg ? "R7 fall-through" : "R8 next_pc"),
        next_pc, exp_pc);
    if (busy_poke) chk(next_pc == exp_pc, "R10 start while busy ignored", next_pc, exp_pc);
    chk(rcnt == (exp_leg ? 4 : 1), "R2 read count", rcnt, exp_leg ? 4 : 1);
    chk(rlog[0] == a, "R2 opcode address", rlog[0], a);
    if (exp_leg) begin
      chk(rlog[1] == a + 16'd1, "R2 operand address", rlog[1], a + 16'd1);
      chk(rlog[2] == a + 16'd2, "R2 displacement address", rlog[2], a + 16'd2);
      chk(rlog[3] == {8'h00, zp}, "R2 zero-page address", rlog[3], {8'h00, zp});
    end
    @(negedge clk);
    chk(!done, "R9 done single cycle", done, 0);
    chk(next_pc == exp_pc && taken == exp_tk, "R9 result held", next_pc, exp_pc);
  endtask

  task automatic t_reset;
    chk(!done && !taken && !illegal && !busy && !mem_rd, "R1 reset flags",
        {done, taken, illegal, busy, mem_rd}, 0);
    chk(next_pc == 16'h0000, "R1 reset next_pc", next_pc, 0);
  endtask

  task automatic t_example;
    run(16'h2000, 8'hB7, 8'h04, 8'hF1, 8'h00, 0);
    chk(next_pc == 16'h1FF4, "R6 worked example A-12", next_pc, 16'h1FF4);
    run(16'h2000, 8'hB7, 8'h04, 8'hF1, 8'h20, 0);
    chk(next_pc == 16'h2003, "R7 worked example A+3", next_pc, 16'h2003);
  endtask

  task automatic t_set;
    run(16'h3100, 8'h47, 8'h80, 8'h10, 8'h04, 0);
    run(16'h3100, 8'h47, 8'h80, 8'h10, 8'hFB, 0);
  endtask

  task automatic t_bits;
    for (int b = 0; b < 8; b++) begin
      run(16'h4010, {3'(b), 5'h07}, 8'h55, 8'h08, 8'(1 << b), 0);
      chk(taken, "R3 bit select set", taken, 1);
      run(16'h4010, {3'(b), 5'h17}, 8'h55, 8'h08, 8'(1 << b), 0);
      chk(!taken, "R3 bit select clear", taken, 0);
    end
  endtask

  task automatic t_wrap;
    run(16'hFFF0, 8'h07, 8'h30, 8'h7F, 8'h01, 0);
    chk(next_pc == 16'h0072, "R6 wrap forward", next_pc, 16'h0072);
    run(16'hFFFE, 8'h17, 8'h40, 8'h02, 8'h00, 0);
    chk(next_pc == 16'h0003, "R6 fetch wrap", next_pc, 16'h0003);
    run(16'h0001, 8'h17, 8'h40, 8'h80, 8'h00, 0);
    chk(next_pc == 16'hFF84, "R6 wrap backward", next_pc, 16'hFF84);
  endtask

  task automatic t_illegal;
    run(16'h5200, 8'h1F, 8'h60, 8'h01, 8'h00, 0);
    run(16'h5300, 8'hA0, 8'h60, 8'h01, 8'hFF, 0);
  endtask

  task automatic t_busy;
    run(16'h6000, 8'h67, 8'h70, 8'hFE, 8'h08, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_example();
    t_set();
    t_bits();
    t_wrap();
    t_illegal();
    t_busy();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule